// File: doc/BRIEF.md
# Cascadable Four-Bit Magnitude Comparator

This block compares two unsigned data words, A and B, and reports one of three results: A greater than B, A equal to B, or A less than B. The most significant bit of each word has the highest weight. It compares by plain unsigned magnitude, so binary, BCD and any other code whose order follows its numeric value all work. The block is purely combinational.

Three cascade inputs extend the comparison downward. They act as a result from positions below bit 0. When the words differ, the data alone decides the outputs. When the words match, the cascade inputs pass the decision through. Wider words are built by chaining stages: the three outputs of a less significant stage drive the cascade inputs of the next more significant stage. The least significant stage has its cascade inputs tied to "equal" (greater=0, equal=1, less=0).

The block also gives a fixed answer when the cascade inputs do not carry exactly one asserted line. This pattern is specified below so that a stage behaves the same under every input combination.

Top module: `magcomp_cascade`

## Requirements
- R1: With the cascade inputs tied to greater=0, equal=1, less=0, the outputs show the plain unsigned comparison of A and B. Bit W-1 is the most significant. The output code is {a_gt_b, a_eq_b, a_lt_b}.
- R2: If A is greater than B, the output code is 100, whatever the cascade inputs are.
- R3: If A is less than B, the output code is 001, whatever the cascade inputs are.
- R4: If A equals B and the cascade equal input is 1, the output code is 010, whatever the other two cascade inputs are.
- R5: If A equals B, the cascade equal input is 0, and exactly one of the cascade greater and less inputs is 1, the output with the same name is the only one asserted (100 or 001).
- R6: If A equals B, the cascade equal input is 0, and both the cascade greater and less inputs are 1, the output code is 000.
- R7: If A equals B and all three cascade inputs are 0, the output code is 101.
- R8: Whenever exactly one cascade input is 1, exactly one output is 1.
- R9: Two stages in series give the correct unsigned comparison of 2W-bit words. In this setup the low stage's outputs drive the high stage's cascade inputs and the low stage's cascade inputs are tied to 010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_word | input | W (4) | First operand, MSB at bit W-1 |
| b_word | input | W (4) | Second operand, MSB at bit W-1 |
| casc_gt_in | input | 1 | Lower-order result: greater |
| casc_eq_in | input | 1 | Lower-order result: equal |
| casc_lt_in | input | 1 | Lower-order result: less |
| a_gt_b | output | 1 | A ranks above B |
| a_eq_b | output | 1 | A ranks equal to B |
| a_lt_b | output | 1 | A ranks below B |

## Verification
Two decisions are made in every evaluation: the data comparison and the resolution of the cascade inputs. The risk is that the cascade inputs leak into a result that the data should settle alone. To provoke this, the bench applies every pair of words against all eight cascade combinations, including those with several lines high or none high. Results for differing words are judged only against the unsigned order of the words. Results for equal words are judged against the cascade table. A two-stage chain then checks that an equal high half hands the decision to the low stage.

// File: rtl/magcomp_pkg.sv
package magcomp_pkg;

    // Three-line result carried through the datapath
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } rank_t;

    // Outcome of the data-only comparison
    typedef enum logic [1:0] {
        VERDICT_TIE  = 2'b00,
        VERDICT_HIGH = 2'b01,
        VERDICT_LOW  = 2'b10
    } verdict_e;

    localparam rank_t RANK_ABOVE = '{gt: 1'b1, eq: 1'b0, lt: 1'b0};
    localparam rank_t RANK_BELOW = '{gt: 1'b0, eq: 1'b0, lt: 1'b1};

    // Result for equal words: pass the lower-order rank, with the
    // fixed pattern for combinations that are not one-hot.
    function automatic rank_t settle_tie(input rank_t lower);
        rank_t r;
        r.eq = lower.eq;
        r.gt = ~lower.eq & ~lower.lt;
        r.lt = ~lower.eq & ~lower.gt;
        return r;
    endfunction

endpackage

// File: rtl/magcomp_slices.sv
module magcomp_slices #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_bits,
    input  logic [W-1:0] b_bits,
    output logic [W-1:0] above_bits,
    output logic [W-1:0] below_bits
);

    // One position-wise decision per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign above_bits[i] = a_bits[i] & ~b_bits[i];
        assign below_bits[i] = ~a_bits[i] & b_bits[i];
    end

endmodule

// File: rtl/magcomp_priority.sv
module magcomp_priority
    import magcomp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] above_bits,
    input  logic [W-1:0] below_bits,
    output verdict_e     verdict
);

    // The highest differing position wins; later iterations override.
    always_comb begin
        verdict = VERDICT_TIE;
        for (int i = 0; i < W; i++) begin
            if (above_bits[i]) begin
                verdict = VERDICT_HIGH;
            end else if (below_bits[i]) begin
                verdict = VERDICT_LOW;
            end
        end
    end

endmodule

// File: rtl/magcomp_merge.sv
module magcomp_merge
    import magcomp_pkg::*;
(
    input  verdict_e verdict,
    input  rank_t    lower,
    output rank_t    result
);

    always_comb begin
        unique case (verdict)
            VERDICT_HIGH: result = RANK_ABOVE;
            VERDICT_LOW:  result = RANK_BELOW;
            default:      result = settle_tie(lower);
        endcase
    end

endmodule

// File: rtl/magcomp_cascade.sv
module magcomp_cascade
    import magcomp_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a_word,
    input  logic [W-1:0] b_word,
    input  logic         casc_gt_in,
    input  logic         casc_eq_in,
    input  logic         casc_lt_in,
    output logic         a_gt_b,
    output logic         a_eq_b,
    output logic         a_lt_b
);

    logic [W-1:0] above_bits;
    logic [W-1:0] below_bits;
    verdict_e     verdict;
    rank_t        lower;
    rank_t        result;

    assign lower = '{gt: casc_gt_in, eq: casc_eq_in, lt: casc_lt_in};

    magcomp_slices #(.W(W)) u_slices (
        .a_bits     (a_word),
        .b_bits     (b_word),
        .above_bits (above_bits),
        .below_bits (below_bits)
    );

    magcomp_priority #(.W(W)) u_priority (
        .above_bits (above_bits),
        .below_bits (below_bits),
        .verdict    (verdict)
    );

    magcomp_merge u_merge (
        .verdict (verdict),
        .lower   (lower),
        .result  (result)
    );

    assign a_gt_b = result.gt;
    assign a_eq_b = result.eq;
    assign a_lt_b = result.lt;

endmodule

// File: rtl/magcomp_cascade_chk.sv
module magcomp_cascade_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] a_word,
    input logic [W-1:0] b_word,
    input logic         casc_gt_in,
    input logic         casc_eq_in,
    input logic         casc_lt_in,
    input logic         a_gt_b,
    input logic         a_eq_b,
    input logic         a_lt_b
);

    logic [2:0] outs;
    logic [2:0] casc;
    assign outs = {a_gt_b, a_eq_b, a_lt_b};
    assign casc = {casc_gt_in, casc_eq_in, casc_lt_in};

    always_comb begin
        if (a_word > b_word) begin
            a_r2_data_above: assert (outs == 3'b100);
        end
        if (a_word < b_word) begin
            a_r3_data_below: assert (outs == 3'b001);
        end
        if (a_word == b_word && casc_eq_in) begin
            a_r4_equal_wins: assert (outs == 3'b010);
        end
        if (a_word == b_word && casc == 3'b100) begin
            a_r5_pass_greater: assert (outs == 3'b100);
        end
        if (a_word == b_word && casc == 3'b001) begin
            a_r5_pass_less: assert (outs == 3'b001);
        end
        if (a_word == b_word && casc == 3'b101) begin
            a_r6_both_high: assert (outs == 3'b000);
        end
        if (a_word == b_word && casc == 3'b000) begin
            a_r7_none_high: assert (outs == 3'b101);
        end
        if ($onehot(casc)) begin
            a_r8_exclusive: assert ($onehot(outs));
        end
    end

endmodule

bind magcomp_cascade magcomp_cascade_chk #(.W(W)) u_chk (
    .a_word     (a_word),
    .b_word     (b_word),
    .casc_gt_in (casc_gt_in),
    .casc_eq_in (casc_eq_in),
    .casc_lt_in (casc_lt_in),
    .a_gt_b     (a_gt_b),
    .a_eq_b     (a_eq_b),
    .a_lt_b     (a_lt_b)
);

// File: tb/magcomp_cascade_test.sv
module magcomp_cascade_test;

    localparam int W = 4;

    typedef struct {
        logic [2:0] exp;
        int         path;    // 0: single stage, 1: two-stage chain
        int         req;
        logic       excl;    // one-hot result also required (R8)
    } item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [W-1:0] a_word, b_word;
    logic         cg, ce, cl;
    logic         o_gt, o_eq, o_lt;

    logic [W-1:0] ah, bh, al, bl;
    logic         lo_gt, lo_eq, lo_lt, hi_gt, hi_eq, hi_lt;

    item_t sb[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    magcomp_cascade #(.W(W)) uut (
        .a_word(a_word), .b_word(b_word),
        .casc_gt_in(cg), .casc_eq_in(ce), .casc_lt_in(cl),
        .a_gt_b(o_gt), .a_eq_b(o_eq), .a_lt_b(o_lt)
    );

    // Two-stage chain for R9
    magcomp_cascade #(.W(W)) lo_stage (
        .a_word(al), .b_word(bl),
        .casc_gt_in(1'b0), .casc_eq_in(1'b1), .casc_lt_in(1'b0),
        .a_gt_b(lo_gt), .a_eq_b(lo_eq), .a_lt_b(lo_lt)
    );
    magcomp_cascade #(.W(W)) hi_stage (
        .a_word(ah), .b_word(bh),
        .casc_gt_in(lo_gt), .casc_eq_in(lo_eq), .casc_lt_in(lo_lt),
        .a_gt_b(hi_gt), .a_eq_b(hi_eq), .a_lt_b(hi_lt)
    );

    // Reference from the requirements
    function automatic logic [2:0] model(int a, int b, logic g, logic e, logic l);
        if (a > b) return 3'b100;          // R2
        if (a < b) return 3'b001;          // R3
        if (e) return 3'b010;              // R4
        case ({g, l})
            2'b10:   return 3'b100;        // R5
            2'b01:   return 3'b001;        // R5
            2'b11:   return 3'b000;        // R6
            default: return 3'b101;        // R7
        endcase
    endfunction

    function automatic int pick_req(int a, int b, logic g, logic e, logic l);
        if ({g, e, l} == 3'b010) return 1; // R1 tie-off
        if (a > b) return 2;
        if (a < b) return 3;
        if (e) return 4;
        if (g ^ l) return 5;
        if (g & l) return 6;
        return 7;
    endfunction

    task automatic drive_single(int a, int b, logic g, logic e, logic l);
        item_t it;
        @(posedge clk);
        #1;
        a_word = a[W-1:0]; b_word = b[W-1:0];
        cg = g; ce = e; cl = l;
        it.exp  = model(a, b, g, e, l);
        it.path = 0;
        it.req  = pick_req(a, b, g, e, l);
        it.excl = $onehot({g, e, l});
        sb.push_back(it);
    endtask

    task automatic drive_chain(int a, int b);
        item_t it;
        @(posedge clk);
        #1;
        ah = a[2*W-1:W]; al = a[W-1:0];
        bh = b[2*W-1:W]; bl = b[W-1:0];
        it.exp  = model(a, b, 1'b0, 1'b1, 1'b0);
        it.path = 1;
        it.req  = 9;                       // R9
        it.excl = 1'b1;
        sb.push_back(it);
    endtask

    // Monitor: compare away from the rising edge
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            item_t it;
            logic [2:0] act;
            it  = sb.pop_front();
            act = (it.path == 0) ? {o_gt, o_eq, o_lt} : {hi_gt, hi_eq, hi_lt};
            checks++;
            if (act !== it.exp) begin
                fails++;
                $display("FAIL R%0d: outputs %b expected %b", it.req, act, it.exp);
            end
            if (it.excl) begin
                checks++;
                if ($countones(act) != 1) begin
                    fails++;
                    $display("FAIL R8: outputs %b expected exactly one set", act);
                end
            end
        end
    end

    initial begin
        int seed;
        a_word = '0; b_word = '0; cg = 1'b0; ce = 1'b1; cl = 1'b0;
        ah = '0; bh = '0; al = '0; bl = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state after reset: tied-off stage, equal words (R1)
        drive_single(0, 0, 1'b0, 1'b1, 1'b0);
        // Exhaustive sweep: R1..R8
        for (int c = 0; c < 8; c++) begin
            for (int a = 0; a < (1 << W); a++) begin
                for (int b = 0; b < (1 << W); b++) begin
                    drive_single(a, b, c[2], c[1], c[0]);
                end
            end
        end
        // BCD-style operands under the tie-off (R1)
        drive_single(9, 8, 1'b0, 1'b1, 1'b0);
        drive_single(3, 7, 1'b0, 1'b1, 1'b0);
        // Two-stage chain (R9): equal high halves hand off to low stage
        drive_chain(8'h5A, 8'h5B);
        drive_chain(8'h5C, 8'h5B);
        drive_chain(8'h77, 8'h77);
        drive_chain(8'h80, 8'h7F);
        drive_chain(8'h0F, 8'h10);
        seed = 17;
        for (int k = 0; k < 300; k++) begin
            int x, y;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            x = (seed >> 8) & 8'hFF;
            seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
            y = (k % 4 == 0) ? ((x & 8'hF0) | ((seed >> 8) & 8'h0F)) : ((seed >> 8) & 8'hFF);
            drive_chain(x, y);
        end
        repeat (3) @(posedge clk);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule